// File: doc/BRIEF.md
# Sixteen-Pin General-Purpose I/O Port

A bank of sixteen bidirectional pins driven from a small register bus. Each pin is an input or an output according to its own direction bit. Software changes output values either by writing a whole word to the output-data register, or by writing a one-hot or multi-bit mask to one of three modify registers. These registers set, clear or invert only the selected pins. Bits written as zero change nothing, so several agents can update their own pins without a read-modify-write sequence.

Pin levels pass through a two-flop synchronizer. The synchronized levels are returned by the level register and feed a level-sensitive interrupt. Interrupt enables also have their own set and clear registers. The interrupt output is high whenever any pin that is both enabled and configured as an input reads high.

Top module: `gpio_port`

## Requirements
- R1: After reset the direction register, the output latch and the interrupt-enable register are all zero, so every pin is an input and the interrupt output is low.
- R2: A write to address 0 (output data) loads all 16 output-latch bits, and reading address 0 returns the latch.
- R3: A write to address 1 (bit set) sets every latch bit whose written bit is 1 and leaves every other latch bit unchanged.
- R4: A write to address 2 (bit clear) clears every latch bit whose written bit is 1 and leaves every other latch bit unchanged.
- R5: A write to address 3 (bit invert) inverts every latch bit whose written bit is 1 and leaves every other latch bit unchanged.
- R6: A write to address 4 (direction) loads the direction register, and reading address 4 returns it. Bit n = 1 makes pin n an output. pad_oe_o equals the direction register, and pad_o equals the output latch.
- R7: Reading address 5 (level) returns pad_i delayed by two clock edges. Writes to address 5 have no effect.
- R8: A write to address 6 sets the interrupt-enable bits selected by ones in the written word. A write to address 7 clears them. Reading either address returns the enable register.
- R9: irq_o is high exactly when some pin n has enable bit n = 1, direction bit n = 0, and synchronized level n = 1. It is a registered output, valid one clock after the enable, direction and level values it depends on.
- R10: Read data is combinational from the address. Reads have no side effects.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| we_i | input | 1 | Write strobe, one cycle per write |
| addr_i | input | 3 | Register address |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data for addr_i |
| pad_i | input | 16 | Sensed pin levels |
| pad_o | output | 16 | Output latch to pin drivers |
| pad_oe_o | output | 16 | Output enables to pin drivers |
| irq_o | output | 1 | Level interrupt |

## Verification
The assertions assume that pad_i is already settled when it is sampled, so the first synchronizer stage never resolves a metastable value. The bench keeps this true by changing pad_i only on the falling clock edge. The assertions also assume that addr_i and wdata_i are stable whenever we_i is high. The bench drives the whole bus together on the falling edge and holds it for a full cycle. The irq check assumes one write per cycle, which is the only way the bus is ever driven.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  localparam int unsigned NPINS = 16;
  localparam int unsigned AW    = 3;
  typedef enum logic [AW-1:0] {
    A_DATA = 3'd0,
    A_SET  = 3'd1,
    A_CLR  = 3'd2,
    A_TGL  = 3'd3,
    A_DIR  = 3'd4,
    A_LVL  = 3'd5,
    A_IESET = 3'd6,
    A_IECLR = 3'd7
  } gpio_addr_e;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int unsigned W = 16,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg [STAGES];
  for (genvar s = 0; s < STAGES; s++) begin : g_stg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stg[s] <= '0;
      else if (s == 0) stg[s] <= d_i;
      else stg[s] <= stg[(s == 0) ? 0 : s-1];
    end
  end
  assign q_o = stg[STAGES-1];
endmodule

// File: rtl/gpio_mod_reg.sv
// Register with word-load plus optional set/clear/invert masks.
module gpio_mod_reg #(
  parameter int unsigned W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         ld_i,
  input  logic         set_i,
  input  logic         clr_i,
  input  logic         tgl_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] nxt;
  always_comb begin
    nxt = q_o;
    if (ld_i)  nxt = wdata_i;
    if (set_i) nxt = q_o | wdata_i;
    if (clr_i) nxt = q_o & ~wdata_i;
    if (tgl_i) nxt = q_o ^ wdata_i;
  end
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_o <= '0;
    else q_o <= nxt;
  end

`ifndef SYNTHESIS
  // R3
  set_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> ((q_o & $past(wdata_i)) == $past(wdata_i)) &&
              ((q_o & ~$past(wdata_i)) == ($past(q_o) & ~$past(wdata_i))));
  // R4
  clr_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> ((q_o & $past(wdata_i)) == '0) &&
              ((q_o & ~$past(wdata_i)) == ($past(q_o) & ~$past(wdata_i))));
  // R5
  tgl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tgl_i |=> (q_o ^ $past(q_o)) == $past(wdata_i));
  // R10
  idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ld_i || set_i || clr_i || tgl_i) |=> $stable(q_o));
`endif
endmodule

// File: rtl/gpio_port.sv
module gpio_port
  import gpio_pkg::*;
#(
  parameter int unsigned W = NPINS
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [W-1:0]  wdata_i,
  output logic [W-1:0]  rdata_o,
  input  logic [W-1:0]  pad_i,
  output logic [W-1:0]  pad_o,
  output logic [W-1:0]  pad_oe_o,
  output logic          irq_o
);
  logic [W-1:0] out_q, dir_q, ie_q, lvl;
  gpio_addr_e   a;
  assign a = gpio_addr_e'(addr_i);

  gpio_mod_reg #(.W(W)) u_out (
    .clk_i, .rst_ni,
    .ld_i (we_i && a == A_DATA),
    .set_i(we_i && a == A_SET),
    .clr_i(we_i && a == A_CLR),
    .tgl_i(we_i && a == A_TGL),
    .wdata_i, .q_o(out_q)
  );

  gpio_mod_reg #(.W(W)) u_dir (
    .clk_i, .rst_ni,
    .ld_i (we_i && a == A_DIR),
    .set_i(1'b0), .clr_i(1'b0), .tgl_i(1'b0),
    .wdata_i, .q_o(dir_q)
  );

  gpio_mod_reg #(.W(W)) u_ie (
    .clk_i, .rst_ni,
    .ld_i (1'b0),
    .set_i(we_i && a == A_IESET),
    .clr_i(we_i && a == A_IECLR),
    .tgl_i(1'b0),
    .wdata_i, .q_o(ie_q)
  );

  gpio_sync #(.W(W), .STAGES(2)) u_sync (
    .clk_i, .rst_ni, .d_i(pad_i), .q_o(lvl)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_o <= 1'b0;
    else irq_o <= |(ie_q & ~dir_q & lvl);
  end

  always_comb begin
    unique case (a)
      A_DATA, A_SET, A_CLR, A_TGL: rdata_o = out_q;
      A_DIR:                       rdata_o = dir_q;
      A_LVL:                       rdata_o = lvl;
      default:                     rdata_o = ie_q;
    endcase
  end

  assign pad_o    = out_q;
  assign pad_oe_o = dir_q;

`ifndef SYNTHESIS
  // R9
  irq_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> $past(|(ie_q & ~dir_q & lvl)));
  // R7
  lvl_sync_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rst_ni) && $past(rst_ni, 2) |-> lvl == $past(pad_i, 2));
  // R6
  dir_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && a == A_DIR) |=> pad_oe_o == $past(wdata_i));
  // R8
  ie_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && a == A_IECLR) |=> (ie_q & $past(wdata_i)) == '0);
`endif
endmodule

// File: tb/gpio_port_test.sv
`timescale 1ns/1ps
module gpio_port_test;
  logic        clk = 0, rst_n = 0, we = 0;
  logic [2:0]  addr = 0;
  logic [15:0] wdata = 0, pad_in = 0;
  logic [15:0] rdata, pad_out, pad_oe;
  logic        irq;
  int checks = 0, fails = 0;

  always #10 clk = ~clk;

  gpio_port uut (
    .clk_i(clk), .rst_ni(rst_n), .we_i(we), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .pad_i(pad_in), .pad_o(pad_out), .pad_oe_o(pad_oe), .irq_o(irq)
  );

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk); we = 1; addr = a; wdata = d;
    @(negedge clk); we = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] d);
    @(negedge clk); addr = a; #1 d = rdata;
  endtask

  typedef struct packed { logic [2:0] a; logic [15:0] d; logic [15:0] exp; } vec_t;
  localparam vec_t VEC [10] = '{
    '{3'd0, 16'hA5C3, 16'hA5C3},  // R2 load
    '{3'd1, 16'h0F00, 16'hAFC3},  // R3 set
    '{3'd1, 16'h0000, 16'hAFC3},  // R3 zero mask
    '{3'd2, 16'h8003, 16'h2FC0},  // R4 clear
    '{3'd2, 16'h0000, 16'h2FC0},  // R4 zero mask
    '{3'd3, 16'hFFFF, 16'hD03F},  // R5 invert all
    '{3'd3, 16'h0001, 16'hD03E},  // R5 single bit
    '{3'd5, 16'hFFFF, 16'hD03E},  // R7 write to level ignored
    '{3'd1, 16'hFFFF, 16'hFFFF},  // R3 set all
    '{3'd2, 16'hFFFF, 16'h0000}   // R4 clear all
  };

  initial begin
    logic [15:0] r;
    #35 ;
    // R1 reset state
    chk("R1 pad_o", pad_out, 16'h0);
    chk("R1 pad_oe", pad_oe, 16'h0);
    chk("R1 irq", {15'b0, irq}, 16'h0);
    rst_n = 1;
    rd(3'd6, r); chk("R1 ie", r, 16'h0);

    foreach (VEC[i]) begin
      wr(VEC[i].a, VEC[i].d);
      rd(3'd0, r); chk("R2-5 vec latch", r, VEC[i].exp);
      chk("R6 pad_o follows latch", pad_out, VEC[i].exp);
    end

    // R6 direction
    wr(3'd4, 16'h00F0);
    rd(3'd4, r); chk("R6 dir read", r, 16'h00F0);
    chk("R6 pad_oe", pad_oe, 16'h00F0);

    // R7 two-edge delay
    @(negedge clk); pad_in = 16'h1234; addr = 3'd5;
    @(negedge clk); #1 chk("R7 one edge", rdata, 16'h0000);
    @(negedge clk); #1 chk("R7 two edges", rdata, 16'h1234);

    // R8 enable set/clear
    wr(3'd6, 16'h0030);
    rd(3'd7, r); chk("R8 ie set", r, 16'h0030);
    @(negedge clk); #1 chk("R9 enabled pins are outputs", {15'b0, irq}, 16'h0);
    wr(3'd6, 16'h0200);
    @(negedge clk); #1 chk("R9 enabled input high", {15'b0, irq}, 16'h1);
    wr(3'd7, 16'h0200);
    rd(3'd6, r); chk("R8 ie clear", r, 16'h0030);
    @(negedge clk); #1 chk("R9 disabled", {15'b0, irq}, 16'h0);
    // R9 direction flip makes enabled pin 4 an input; pad bit 4 = 1
    wr(3'd4, 16'h0000);
    @(negedge clk); #1 chk("R9 dir to input", {15'b0, irq}, 16'h1);
    pad_in = 16'h0000;
    @(negedge clk); @(negedge clk); @(negedge clk); #1
    chk("R9 level low", {15'b0, irq}, 16'h0);
    // R10 reads have no side effects
    rd(3'd0, r); rd(3'd0, r); chk("R10 latch after reads", pad_out, 16'h0000);
    rd(3'd6, r); chk("R10 ie after reads", r, 16'h0030);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule